// File: doc/BRIEF.md
# Bus Cycle Ordering Arbiter

This block chooses which cycle goes onto the external bus next for a simple in-order core. Buffered memory writes wait in a small FIFO, each tagged with whether it hit in the on-chip cache. The core also presents one ordered operation at a time: a memory read miss, an I/O read, an I/O write, or a locked read-modify-write. The arbiter interleaves these with the buffered writes. Program-order rules are kept, and a read miss may go early only when doing so is provably safe.

A read miss may overtake the buffered writes only when every valid entry is a cache hit. A hit cannot alias the missed line, so the early read cannot return stale data. In every other case, including I/O and locked operations, the buffer drains completely first. A locked operation always goes to external memory. It runs as a read followed by a write to the same address, with the bus lock signal held across both. It either exchanges the location with an operand or adds the operand to it, and it returns the old value. The core keeps `op_req_i` and its fields steady until `op_done_o` pulses, then drops the request. It pushes no writes while an operation is outstanding, so every buffered entry is older than the operation.

Top module: `bus_order_arb`

## Requirements
- R1: After reset, `bus_req_o`, `bus_lock_o` and `op_done_o` are low and `wr_rdy_o` is high.
- R2: Buffered writes reach the bus in push order as cycles with `bus_we_o`=1, `bus_io_o`=0 and `bus_lock_o`=0. With DEPTH entries held, `wr_rdy_o` is low and a further push is dropped and never appears on the bus.
- R3: A read miss (`op_kind_i`=0) is put on the bus ahead of pending writes when all pending writes are cache hits. It returns the external memory contents.
- R4: When any pending write is a cache miss, a read miss waits until the buffer is empty, so it observes the data of every older write.
- R5: An I/O read (`op_kind_i`=1) or I/O write (`op_kind_i`=2) issues only with the buffer empty, with `bus_io_o`=1. An I/O write does not modify memory. An I/O read returns the bus read data.
- R6: A locked operation issues only with the buffer empty. It consists of a locked read and then a locked write to the same address, both granted with `bus_lock_o`=1. `bus_lock_o` rises in the cycle the locked read is presented and falls in the cycle after the locked write is granted. No other cycle is granted in between.
- R7: A locked exchange (`op_kind_i`=3) writes `op_wdata_i`. A locked add (`op_kind_i`=4) writes the old value plus `op_wdata_i`. Both return the old value on `op_rdata_o`.
- R8: `op_done_o` is a one-cycle pulse in the cycle after the operation's final bus cycle is granted. `op_rdata_o` carries the result in that same cycle.
- R9: With no operation pending, buffered writes are presented back to back, one per granted cycle.
- R10: The all-hits decision is recomputed every cycle. Once the last missing entry has drained, a waiting read overtakes the remaining hit entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_push_i | input | 1 | Push a buffered write |
| wr_addr_i | input | AW | Write address |
| wr_data_i | input | DW | Write data |
| wr_hit_i | input | 1 | Write hit in the on-chip cache |
| wr_rdy_o | output | 1 | Buffer can accept a push |
| op_req_i | input | 1 | Ordered operation request, held until done |
| op_kind_i | input | 3 | 0 read miss, 1 I/O read, 2 I/O write, 3 locked exchange, 4 locked add |
| op_addr_i | input | AW | Operation address |
| op_wdata_i | input | DW | I/O write data or locked operand |
| op_done_o | output | 1 | Operation complete pulse |
| op_rdata_o | output | DW | Operation result |
| bus_req_o | output | 1 | Bus cycle requested |
| bus_we_o | output | 1 | Cycle is a write |
| bus_io_o | output | 1 | Cycle targets I/O space |
| bus_lock_o | output | 1 | Bus lock held |
| bus_addr_o | output | AW | Cycle address |
| bus_wdata_o | output | DW | Cycle write data |
| bus_gnt_i | input | 1 | Cycle granted and completed this clock |
| bus_rdata_i | input | DW | Read data, valid with the grant |

## Verification
A corrupted miss count in the write buffer shows up in the very next cycle a read is pending. Either a read is presented while a missing write is still queued, so it returns stale data, or writes are drained that should have been overtaken. A lock sequencer stuck in its write phase keeps `bus_lock_o` high and blocks every other cycle from the next clock. A head pointer off by one reorders the bus write log at the first drain. Each scenario is run with the bus stalled while the request is set up, so the first presented cycle can be inspected before any grant. The bus log then confirms the full order.

// File: rtl/bus_order_pkg.sv
package bus_order_pkg;
  typedef enum logic [2:0] {
    OP_READ    = 3'd0,
    OP_IO_RD   = 3'd1,
    OP_IO_WR   = 3'd2,
    OP_LK_XCHG = 3'd3,
    OP_LK_ADD  = 3'd4
  } op_kind_e;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_WBUF,
    CYC_READ,
    CYC_IO,
    CYC_LK_RD,
    CYC_LK_WR
  } cyc_e;
endpackage

// File: rtl/bo_wbuf.sv
module bo_wbuf #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          hit_i,
  input  logic          pop_i,
  output logic          empty_o,
  output logic          full_o,
  output logic          all_hits_o,
  output logic [AW-1:0] head_addr_o,
  output logic [DW-1:0] head_data_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [DEPTH-1:0] hit_q;
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q, miss_q;
  logic push_ok, pop_ok, push_miss, pop_miss;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign all_hits_o = (miss_q == '0);
  assign push_ok    = push_i && !full_o;
  assign pop_ok     = pop_i && !empty_o;
  assign push_miss  = push_ok && !hit_i;
  assign pop_miss   = pop_ok && !hit_q[rp_q];
  assign head_addr_o = addr_q[rp_q];
  assign head_data_o = data_q[rp_q];

  // storage entries carry no reset; validity is tracked by cnt_q
  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (push_ok && wp_q == PW'(g)) begin
        addr_q[g] <= addr_i;
        data_q[g] <= data_i;
        hit_q[g]  <= hit_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q   <= '0;
      rp_q   <= '0;
      cnt_q  <= '0;
      miss_q <= '0;
    end else begin
      if (push_ok) wp_q <= ptr_inc(wp_q);
      if (pop_ok)  rp_q <= ptr_inc(rp_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
      case ({push_miss, pop_miss})
        2'b10:   miss_q <= miss_q + CW'(1);
        2'b01:   miss_q <= miss_q - CW'(1);
        default: miss_q <= miss_q;
      endcase
    end
  end
endmodule

// File: rtl/bo_pick.sv
module bo_pick
  import bus_order_pkg::*;
(
  input  logic     op_vld_i,
  input  op_kind_e op_kind_i,
  input  logic     wb_empty_i,
  input  logic     wb_all_hits_i,
  input  logic     lk_wr_i,
  output cyc_e     cyc_o
);
  always_comb begin
    cyc_o = CYC_NONE;
    if (lk_wr_i) begin
      cyc_o = CYC_LK_WR;
    end else if (op_vld_i) begin
      unique case (op_kind_i)
        OP_READ:              cyc_o = (wb_empty_i || wb_all_hits_i) ? CYC_READ : CYC_WBUF;
        OP_IO_RD, OP_IO_WR:   cyc_o = wb_empty_i ? CYC_IO : CYC_WBUF;
        OP_LK_XCHG, OP_LK_ADD: cyc_o = wb_empty_i ? CYC_LK_RD : CYC_WBUF;
        default:              cyc_o = wb_empty_i ? CYC_NONE : CYC_WBUF;
      endcase
    end else if (!wb_empty_i) begin
      cyc_o = CYC_WBUF;
    end
  end
endmodule

// File: rtl/bo_lock.sv
module bo_lock #(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_done_i,
  input  logic          wr_done_i,
  input  logic [DW-1:0] rdata_i,
  input  logic          add_i,
  input  logic [DW-1:0] operand_i,
  output logic          wr_phase_o,
  output logic [DW-1:0] old_o,
  output logic [DW-1:0] wdata_o
);
  logic          wr_q;
  logic [DW-1:0] old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= 1'b0;
      old_q <= '0;
    end else if (rd_done_i) begin
      wr_q  <= 1'b1;
      old_q <= rdata_i;
    end else if (wr_done_i) begin
      wr_q  <= 1'b0;
    end
  end

  assign wr_phase_o = wr_q;
  assign old_o      = old_q;
  assign wdata_o    = add_i ? old_q + operand_i : operand_i;
endmodule

// File: rtl/bus_order_arb.sv
module bus_order_arb
  import bus_order_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_push_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_hit_i,
  output logic          wr_rdy_o,
  input  logic          op_req_i,
  input  logic [2:0]    op_kind_i,
  input  logic [AW-1:0] op_addr_i,
  input  logic [DW-1:0] op_wdata_i,
  output logic          op_done_o,
  output logic [DW-1:0] op_rdata_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic          bus_io_o,
  output logic          bus_lock_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_gnt_i,
  input  logic [DW-1:0] bus_rdata_i
);
  op_kind_e      kind;
  cyc_e          cyc;
  logic          wb_empty, wb_full, wb_all_hits, wb_pop;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic          op_vld, lk_wr, lk_add;
  logic [DW-1:0] lk_old, lk_wdata;
  logic          done_q;
  logic [DW-1:0] rdata_q;
  logic          granted, finish;

  assign kind    = op_kind_e'(op_kind_i);
  assign op_vld  = op_req_i && !done_q;  // request already served this cycle
  assign granted = bus_req_o && bus_gnt_i;
  assign wb_pop  = granted && (cyc == CYC_WBUF);
  assign lk_add  = (kind == OP_LK_ADD);
  assign finish  = granted && (cyc == CYC_READ || cyc == CYC_IO || cyc == CYC_LK_WR);

  bo_wbuf #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_wbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (wr_push_i),
    .addr_i      (wr_addr_i),
    .data_i      (wr_data_i),
    .hit_i       (wr_hit_i),
    .pop_i       (wb_pop),
    .empty_o     (wb_empty),
    .full_o      (wb_full),
    .all_hits_o  (wb_all_hits),
    .head_addr_o (wb_addr),
    .head_data_o (wb_data)
  );

  bo_pick u_pick (
    .op_vld_i      (op_vld),
    .op_kind_i     (kind),
    .wb_empty_i    (wb_empty),
    .wb_all_hits_i (wb_all_hits),
    .lk_wr_i       (lk_wr),
    .cyc_o         (cyc)
  );

  bo_lock #(.DW(DW)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_done_i  (granted && cyc == CYC_LK_RD),
    .wr_done_i  (granted && cyc == CYC_LK_WR),
    .rdata_i    (bus_rdata_i),
    .add_i      (lk_add),
    .operand_i  (op_wdata_i),
    .wr_phase_o (lk_wr),
    .old_o      (lk_old),
    .wdata_o    (lk_wdata)
  );

  assign wr_rdy_o   = !wb_full;
  assign bus_req_o  = (cyc != CYC_NONE);
  assign bus_io_o   = (cyc == CYC_IO);
  assign bus_lock_o = (cyc == CYC_LK_RD) || (cyc == CYC_LK_WR);
  assign bus_we_o   = (cyc == CYC_WBUF) || (cyc == CYC_LK_WR) ||
                      ((cyc == CYC_IO) && (kind == OP_IO_WR));
  assign bus_addr_o = (cyc == CYC_WBUF) ? wb_addr : op_addr_i;

  always_comb begin
    unique case (cyc)
      CYC_WBUF:  bus_wdata_o = wb_data;
      CYC_LK_WR: bus_wdata_o = lk_wdata;
      CYC_IO:    bus_wdata_o = op_wdata_i;
      default:   bus_wdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= finish;
      if (finish) begin
        if (cyc == CYC_LK_WR)   rdata_q <= lk_old;
        else if (bus_we_o)      rdata_q <= '0;
        else                    rdata_q <= bus_rdata_i;
      end
    end
  end

  assign op_done_o  = done_q;
  assign op_rdata_o = rdata_q;
endmodule

// File: rtl/bus_order_arb_chk.sv
module bus_order_arb_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_push_i,
  input logic [AW-1:0] wr_addr_i,
  input logic [DW-1:0] wr_data_i,
  input logic          wr_hit_i,
  input logic          wr_rdy_o,
  input logic          op_req_i,
  input logic [2:0]    op_kind_i,
  input logic [AW-1:0] op_addr_i,
  input logic [DW-1:0] op_wdata_i,
  input logic          op_done_o,
  input logic [DW-1:0] op_rdata_o,
  input logic          bus_req_o,
  input logic          bus_we_o,
  input logic          bus_io_o,
  input logic          bus_lock_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [DW-1:0] bus_wdata_o,
  input logic          bus_gnt_i,
  input logic [DW-1:0] bus_rdata_i
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    sh_addr [DEPTH];
  logic [DW-1:0]    sh_data [DEPTH];
  logic [DEPTH-1:0] sh_hit;
  logic [PW-1:0]    sh_wp, sh_rp;
  logic [CW-1:0]    sh_cnt, sh_miss;
  logic             s_push, s_pop, rd_gnt, alias_hit;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign s_push = wr_push_i && wr_rdy_o;
  assign s_pop  = bus_req_o && bus_gnt_i && bus_we_o && !bus_io_o && !bus_lock_o;
  assign rd_gnt = bus_req_o && bus_gnt_i && !bus_we_o && !bus_io_o && !bus_lock_o;

  always_ff @(posedge clk_i) begin
    if (s_push) begin
      sh_addr[sh_wp] <= wr_addr_i;
      sh_data[sh_wp] <= wr_data_i;
      sh_hit[sh_wp]  <= wr_hit_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_wp <= '0; sh_rp <= '0; sh_cnt <= '0; sh_miss <= '0;
    end else begin
      if (s_push) sh_wp <= nxt(sh_wp);
      if (s_pop)  sh_rp <= nxt(sh_rp);
      sh_cnt  <= sh_cnt + CW'(s_push) - CW'(s_pop);
      sh_miss <= sh_miss + CW'(s_push && !wr_hit_i) - CW'(s_pop && !sh_hit[sh_rp]);
    end
  end

  always_comb begin
    alias_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(sh_cnt) && sh_addr[(int'(sh_rp) + i) % DEPTH] == bus_addr_o)
        alias_hit = 1'b1;
    end
  end

  // R3
  no_read_alias_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_gnt |-> !alias_hit);

  // R4
  read_after_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_gnt |-> (sh_miss == '0));

  // R2
  write_fifo_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_pop |-> (sh_cnt != '0) && bus_addr_o == sh_addr[sh_rp] && bus_wdata_o == sh_data[sh_rp]);

  // R5
  io_drained_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_io_o) |-> (sh_cnt == '0));

  // R6
  lock_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_lock_o) |-> (sh_cnt == '0) && bus_req_o && !bus_we_o);

  // R6
  lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && bus_gnt_i && !bus_we_o) |=> bus_lock_o && bus_we_o && $stable(bus_addr_o));

  // R6
  lock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_lock_o && bus_gnt_i && bus_we_o) |=> !bus_lock_o);

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_o |=> !op_done_o);
endmodule

bind bus_order_arb bus_order_arb_chk #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_bus_order_arb.sv
module tb_bus_order_arb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_push = 1'b0, wr_hit = 1'b0, wr_rdy;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic op_req = 1'b0, op_done;
  logic [2:0] op_kind = '0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0, op_rdata;
  logic bus_req, bus_we, bus_io, bus_lock, bus_gnt;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic gnt_en = 1'b0;

  logic [DW-1:0] mem [16];
  logic [DW-1:0] exp_mem [16];
  logic          log_we [64];
  logic          log_io [64];
  logic          log_lk [64];
  logic [AW-1:0] log_addr [64];
  logic [DW-1:0] log_data [64];
  int log_n = 0;
  int lock_cyc = 0;
  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_order_arb #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_push_i(wr_push), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .wr_hit_i(wr_hit), .wr_rdy_o(wr_rdy),
    .op_req_i(op_req), .op_kind_i(op_kind), .op_addr_i(op_addr), .op_wdata_i(op_wdata),
    .op_done_o(op_done), .op_rdata_o(op_rdata),
    .bus_req_o(bus_req), .bus_we_o(bus_we), .bus_io_o(bus_io), .bus_lock_o(bus_lock),
    .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata), .bus_gnt_i(bus_gnt), .bus_rdata_i(bus_rdata)
  );

  assign bus_gnt   = bus_req && gnt_en;
  assign bus_rdata = bus_io ? {16'hA5A5, bus_addr} : mem[bus_addr[3:0]];

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem[i] = 32'h100 + i;
      exp_mem[i] = 32'h100 + i;
    end
  end

  // external memory model and bus log
  always @(posedge clk) begin
    if (rst_n) begin
      if (bus_lock) lock_cyc++;
      if (bus_req && bus_gnt) begin
        if (log_n < 64) begin
          log_we[log_n] = bus_we; log_io[log_n] = bus_io; log_lk[log_n] = bus_lock;
          log_addr[log_n] = bus_addr; log_data[log_n] = bus_wdata;
          log_n++;
        end
        if (bus_we && !bus_io) mem[bus_addr[3:0]] <= bus_wdata;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic h);
    @(negedge clk);
    wr_push = 1'b1; wr_addr = a; wr_data = d; wr_hit = h;
    if (wr_rdy) exp_mem[a[3:0]] = d;
    @(negedge clk);
    wr_push = 1'b0;
  endtask

  task automatic op_start(input logic [2:0] k, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    op_req = 1'b1; op_kind = k; op_addr = a; op_wdata = d;
  endtask

  task automatic op_finish(output logic [DW-1:0] r);
    int n;
    gnt_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!op_done && n < 100);
    r = op_rdata;
    op_req = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic chk_log(input int i, input logic we, input logic io, input logic lk,
                         input logic [AW-1:0] a, input string req);
    chk(i < log_n && log_we[i] == we && log_io[i] == io && log_lk[i] == lk && log_addr[i] == a,
        req, {log_we[i], log_io[i], log_lk[i], 13'd0, log_addr[i]}, {we, io, lk, 13'd0, a});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!bus_req && !bus_lock && !op_done && wr_rdy, "R1 reset outputs",
        {bus_req, bus_lock, op_done, wr_rdy}, 32'h1);
  endtask

  task automatic t_fifo();
    gnt_en = 1'b0; log_n = 0;
    push(16'd3, 32'hA3, 1'b1);
    push(16'd5, 32'hA5, 1'b0);
    push(16'd7, 32'hA7, 1'b1);
    @(negedge clk);
    gnt_en = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(log_n == 2, "R9 back-to-back drain", log_n, 2);
    repeat (4) @(negedge clk);
    chk(log_n == 3, "R2 drain count", log_n, 3);
    chk_log(0, 1, 0, 0, 16'd3, "R2 order 0");
    chk_log(1, 1, 0, 0, 16'd5, "R2 order 1");
    chk_log(2, 1, 0, 0, 16'd7, "R2 order 2");
    chk(mem[5] == 32'hA5, "R2 memory written", mem[5], 32'hA5);
  endtask

  task automatic t_full();
    gnt_en = 1'b0; log_n = 0;
    for (int i = 0; i < DEPTH; i++) push(AW'(8 + i), 32'hB0 + i, 1'b1);
    chk(!wr_rdy, "R2 full deasserts ready", wr_rdy, 0);
    push(16'd12, 32'hBC, 1'b1);
    @(negedge clk);
    gnt_en = 1'b1;
    repeat (10) @(negedge clk);
    chk(log_n == DEPTH, "R2 overflow push dropped", log_n, DEPTH);
    chk(mem[12] == 32'h10C, "R2 dropped write absent", mem[12], 32'h10C);
    chk_log(DEPTH - 1, 1, 0, 0, 16'd11, "R2 last entry");
  endtask

  task automatic t_bypass();
    logic [DW-1:0] r;
    gnt_en = 1'b0; log_n = 0;
    push(16'd1, 32'hC1, 1'b1);
    push(16'd2, 32'hC2, 1'b1);
    op_start(3'd0, 16'd6, '0);
    @(negedge clk);
    chk(bus_req && !bus_we && !bus_lock && bus_addr == 16'd6, "R3 read presented first",
        {bus_req, bus_we, bus_addr[13:0]}, {2'b10, 14'd6});
    op_finish(r);
    chk(r == exp_mem[6], "R3 R8 read data", r, exp_mem[6]);
    chk_log(0, 0, 0, 0, 16'd6, "R3 read before hits");
    chk_log(1, 1, 0, 0, 16'd1, "R3 hit write after read");
    chk_log(2, 1, 0, 0, 16'd2, "R3 second hit write");
  endtask

  task automatic t_order();
    logic [DW-1:0] r;
    gnt_en = 1'b0; log_n = 0;
    push(16'd1, 32'hD1, 1'b1);
    push(16'd2, 32'hD2, 1'b0);
    op_start(3'd0, 16'd2, '0);
    @(negedge clk);
    chk(bus_req && bus_we && bus_addr == 16'd1, "R4 write presented before read",
        {bus_we, bus_addr[14:0]}, {1'b1, 15'd1});
    op_finish(r);
    chk(r == 32'hD2, "R4 read sees older write", r, 32'hD2);
    chk_log(2, 0, 0, 0, 16'd2, "R4 read last");
  endtask

  task automatic t_recompute();
    logic [DW-1:0] r;
    gnt_en = 1'b0; log_n = 0;
    push(16'd4, 32'hE4, 1'b0);
    push(16'd5, 32'hE5, 1'b1);
    push(16'd6, 32'hE6, 1'b1);
    op_start(3'd0, 16'd9, '0);
    op_finish(r);
    chk_log(0, 1, 0, 0, 16'd4, "R10 miss drains first");
    chk_log(1, 0, 0, 0, 16'd9, "R10 read overtakes remaining hits");
    chk_log(3, 1, 0, 0, 16'd6, "R10 hits follow");
    chk(r == exp_mem[9], "R10 read data", r, exp_mem[9]);
  endtask

  task automatic t_io();
    logic [DW-1:0] r;
    gnt_en = 1'b0; log_n = 0;
    push(16'd3, 32'hF3, 1'b1);
    op_start(3'd1, 16'h0020, '0);
    @(negedge clk);
    chk(bus_req && bus_we && !bus_io, "R5 hit write drains before I/O read",
        {bus_we, bus_io}, 32'h2);
    op_finish(r);
    chk(r == 32'hA5A5_0020, "R5 I/O read data", r, 32'hA5A5_0020);
    chk_log(1, 0, 1, 0, 16'h0020, "R5 I/O read after write");
    log_n = 0;
    op_start(3'd2, 16'h0021, 32'h77);
    op_finish(r);
    chk_log(0, 1, 1, 0, 16'h0021, "R5 I/O write cycle");
    chk(log_data[0] == 32'h77, "R5 I/O write data", log_data[0], 32'h77);
    chk(mem[1] == exp_mem[1], "R5 I/O write leaves memory", mem[1], exp_mem[1]);
  endtask

  task automatic t_lock();
    logic [DW-1:0] r;
    gnt_en = 1'b0; log_n = 0;
    push(16'd10, 32'h9A, 1'b1);
    op_start(3'd3, 16'd13, 32'h55);
    @(negedge clk);
    chk(!bus_lock && bus_we, "R6 lock waits for drain", {bus_lock, bus_we}, 32'h1);
    lock_cyc = 0;
    op_finish(r);
    chk(r == 32'h10D, "R7 exchange returns old", r, 32'h10D);
    chk(mem[13] == 32'h55, "R7 exchange writes operand", mem[13], 32'h55);
    chk_log(1, 0, 0, 1, 16'd13, "R6 locked read");
    chk_log(2, 1, 0, 1, 16'd13, "R6 locked write");
    chk(log_n == 3, "R6 nothing else granted", log_n, 3);
    chk(lock_cyc == 2, "R6 lock held two cycles", lock_cyc, 2);
    chk(!bus_lock, "R6 lock released", bus_lock, 0);
    log_n = 0;
    op_start(3'd4, 16'd13, 32'h5);
    op_finish(r);
    chk(r == 32'h55, "R7 add returns old", r, 32'h55);
    chk(mem[13] == 32'h5A, "R7 add writes sum", mem[13], 32'h5A);
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000 && !finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc_cnt);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fifo();
    t_full();
    t_bypass();
    t_order();
    t_recompute();
    t_io();
    t_lock();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule